// File: doc/BRIEF.md
# Quadrature Encoder Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. Each phase passes through a two-stage synchronizer. Level changes on the synchronized phases are then decoded into single up or down steps. A 2-bit source select decides which phase edges count: none, phase A only, phase B only, or both. Counting on both phases gives four counts per encoder cycle.

The counter runs between 0 and a programmable reload value and wraps in both directions. Each wrap raises a one-cycle event. A direction flag shows the sense of the most recent counted step. Software programs the reload value before it enables counting. After that the count follows the encoder with no further attention.

Top module: `qenc_counter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `count` is 0, `dir_down` is 0 (up) and `wrap_evt` is 0.
- R2: With `mode` = 1, only level changes of phase A move the counter. Level changes of phase B alone leave `count` and `dir_down` unchanged.
- R3: With `mode` = 2, only level changes of phase B move the counter. Level changes of phase A alone leave `count` and `dir_down` unchanged.
- R4: With `mode` = 3, every level change of either phase moves the counter by exactly one. A full encoder cycle therefore gives four steps. The counter never moves by more than one per clock except by wrapping.
- R5: A phase A change counts up when the new levels satisfy A != B. It counts down when A == B. So A rising with B low is up, and A rising with B high is down.
- R6: A phase B change counts up when the new levels satisfy A == B. It counts down when A != B. So B rising with A high is up, and B rising with A low is down.
- R7: `dir_down` is updated on every counted step. It is 1 after a down step and 0 after an up step.
- R8: An up step taken when `count` is at or above `reload` sets `count` to 0 and raises `wrap_evt` for exactly one cycle.
- R9: A down step taken when `count` is 0 sets `count` to `reload` and raises `wrap_evt` for exactly one cycle.
- R10: With `mode` = 0 or `cnt_en` low, `count` and `dir_down` hold. Phase changes seen during that time are not counted once counting resumes.
- R11: A phase change applied before a clock edge shows on `count` after the third rising edge, and not after the second.
- R12: With `mode` = 3, if both synchronized phases change in the same cycle, the change is ignored as an invalid transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| mode | input | 2 | Counting source: 0 off, 1 phase A, 2 phase B, 3 both |
| reload | input | 16 | Upper count limit and wrap target |
| cnt_en | input | 1 | Counter enable |
| count | output | 16 | Current count |
| dir_down | output | 1 | Direction of last counted step, 1 = down |
| wrap_evt | output | 1 | One-cycle pulse on each wrap |

## Verification
The encoder is driven through forward and reverse Gray sequences in the both-phase mode. Those separate the four direction cases of R5 and R6 and show that each edge counts once. The single-phase modes are then driven with edges on both phases. A counter that ignores the source select would count the edges of the unselected phase. Wrap checks run in both directions, including reload values of 0 and below the current count. A simultaneous two-phase change, a disable window followed by re-enable, and a cycle-exact latency probe separate R10 to R12 from plain counting.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int CNT_DEF_W  = 16;
    localparam int SYNC_DEF_N = 2;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2,
        SRC_BOTH = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

    // Sense of a phase A change, judged on the levels after the change.
    function automatic logic up_from_a(input logic a, input logic b);
        return a ^ b;
    endfunction

    // Sense of a phase B change, judged on the levels after the change.
    function automatic logic up_from_b(input logic a, input logic b);
        return ~(a ^ b);
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
    import qenc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl_a,
    input  logic     lvl_b,
    input  src_sel_e sel,
    input  logic     enable,
    output step_t    step
);
    logic prev_a, prev_b;
    logic edge_a, edge_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= lvl_a;
            prev_b <= lvl_b;
        end
    end

    assign edge_a = lvl_a ^ prev_a;
    assign edge_b = lvl_b ^ prev_b;

    always_comb begin
        step = '0;
        unique case (sel)
            SRC_A: begin
                step.valid = edge_a;
                step.up    = up_from_a(lvl_a, lvl_b);
            end
            SRC_B: begin
                step.valid = edge_b;
                step.up    = up_from_b(lvl_a, lvl_b);
            end
            SRC_BOTH: begin
                step.valid = edge_a ^ edge_b;
                step.up    = edge_a ? up_from_a(lvl_a, lvl_b)
                                    : up_from_b(lvl_a, lvl_b);
            end
            default: step = '0;
        endcase
        step.valid = step.valid & enable;
    end
endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter
    import qenc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] value,
    output logic         down,
    output logic         wrapped
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= '0;
            down    <= 1'b0;
            wrapped <= 1'b0;
        end else begin
            wrapped <= 1'b0;
            if (step.valid) begin
                down <= ~step.up;
                if (step.up) begin
                    if (value >= limit) begin
                        value   <= '0;
                        wrapped <= 1'b1;
                    end else begin
                        value <= value + 1'b1;
                    end
                end else begin
                    if (value == '0) begin
                        value   <= limit;
                        wrapped <= 1'b1;
                    end else begin
                        value <= value - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W  = CNT_DEF_W,
    parameter int SYNC_N = SYNC_DEF_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] reload,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap_evt
);
    localparam int PHASES = 2;

    logic [PHASES-1:0] lvl;
    step_t             step;

    qenc_sync #(.STAGES(SYNC_N), .W(PHASES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({phase_b, phase_a}),
        .q   (lvl)
    );

    qenc_step_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .lvl_a  (lvl[0]),
        .lvl_b  (lvl[1]),
        .sel    (src_sel_e'(mode)),
        .enable (cnt_en),
        .step   (step)
    );

    qenc_wrap_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .limit   (reload),
        .value   (count),
        .down    (dir_down),
        .wrapped (wrap_evt)
    );
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode,
    input logic [W-1:0] reload,
    input logic         cnt_en,
    input logic [W-1:0] count,
    input logic         dir_down,
    input logic         wrap_evt
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !dir_down && !wrap_evt));

    p_hold_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en || mode == 2'd0) |=> ($stable(count) && $stable(dir_down) && !wrap_evt));

    p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) ||
                  count == W'($past(count) + 1'b1) ||
                  count == W'($past(count) - 1'b1) ||
                  count == '0 ||
                  count == $past(reload)));

    p_wrap_up_r8: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && !dir_down) |-> count == '0);

    p_wrap_down_r9: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && dir_down) |-> count == $past(reload));
endmodule

bind qenc_counter qenc_counter_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .reload   (reload),
    .cnt_en   (cnt_en),
    .count    (count),
    .dir_down (dir_down),
    .wrap_evt (wrap_evt)
);

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic [1:0]  mode = 2'd3;
    logic [15:0] reload = 16'd5;
    logic        cnt_en = 1'b0;
    logic [15:0] count;
    logic        dir_down;
    logic        wrap_evt;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_cnt = 16'd0;
    logic        exp_dir = 1'b0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qenc_counter i_qenc_counter (
        .clk (clk), .rst (rst), .phase_a (phase_a), .phase_b (phase_b),
        .mode (mode), .reload (reload), .cnt_en (cnt_en),
        .count (count), .dir_down (dir_down), .wrap_evt (wrap_evt)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive new phase levels, wait out sync + decode + count, compare with model.
    task automatic apply(input logic na, input logic nb, input int delta, input string req);
        logic exp_wrap;
        phase_a = na;
        phase_b = nb;
        exp_wrap = 1'b0;
        if (delta > 0) begin
            if (exp_cnt >= reload) begin exp_cnt = 16'd0; exp_wrap = 1'b1; end
            else exp_cnt = exp_cnt + 16'd1;
            exp_dir = 1'b0;
        end else if (delta < 0) begin
            if (exp_cnt == 16'd0) begin exp_cnt = reload; exp_wrap = 1'b1; end
            else exp_cnt = exp_cnt - 16'd1;
            exp_dir = 1'b1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({req, " count"}, count, exp_cnt);
        check({req, " dir_down"}, {15'd0, dir_down}, {15'd0, exp_dir});
        check({req, " wrap_evt"}, {15'd0, wrap_evt}, {15'd0, exp_wrap});
        @(negedge clk);
        check({req, " wrap_evt one cycle R8/R9"}, {15'd0, wrap_evt}, 16'd0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 count", count, 16'd0);
        check("R1 dir_down", {15'd0, dir_down}, 16'd0);
        check("R1 wrap_evt", {15'd0, wrap_evt}, 16'd0);
        rst = 1'b0;
        cnt_en = 1'b1;
        @(negedge clk);
        check("R1 after release", count, 16'd0);
    endtask

    task automatic test_both_up();
        mode = 2'd3;
        apply(1'b1, 1'b0, 1, "R5 A rise B low up");
        apply(1'b1, 1'b1, 1, "R6 B rise A high up");
        apply(1'b0, 1'b1, 1, "R5 A fall B high up");
        apply(1'b0, 1'b0, 1, "R6 B fall A low up");
        check("R4 four steps per cycle", count, 16'd4);
    endtask

    task automatic test_wrap_up();
        apply(1'b1, 1'b0, 1, "R8 reach reload");
        apply(1'b1, 1'b1, 1, "R8 wrap to zero");
        check("R8 count zero", count, 16'd0);
    endtask

    task automatic test_wrap_down();
        apply(1'b1, 1'b0, -1, "R9 wrap to reload R6 down");
        check("R9 count reload", count, 16'd5);
        apply(1'b0, 1'b0, -1, "R5 A fall B low down R7");
    endtask

    task automatic test_latency();
        phase_a = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 no change after two edges", count, 16'd4);
        @(posedge clk);
        @(negedge clk);
        check("R11 change after third edge", count, 16'd5);
        exp_cnt = 16'd5;
        exp_dir = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_mode_a();
        mode = 2'd1;
        apply(1'b1, 1'b1, 0, "R2 B ignored");
        apply(1'b0, 1'b1, 1, "R2 A counts");
        apply(1'b0, 1'b0, 0, "R2 B ignored again");
        apply(1'b1, 1'b0, 1, "R2 A rise up");
    endtask

    task automatic test_mode_b();
        mode = 2'd2;
        apply(1'b0, 1'b0, 0, "R3 A ignored");
        apply(1'b0, 1'b1, -1, "R3 B rise A low down");
        apply(1'b1, 1'b1, 0, "R3 A ignored again");
        apply(1'b1, 1'b0, -1, "R3 B fall A high down");
    endtask

    task automatic test_simultaneous();
        mode = 2'd3;
        apply(1'b0, 1'b1, 0, "R12 both change ignored");
    endtask

    task automatic test_disable();
        mode = 2'd0;
        apply(1'b1, 1'b1, 0, "R10 mode off holds");
        mode = 2'd3;
        cnt_en = 1'b0;
        apply(1'b1, 1'b0, 0, "R10 enable low holds");
        cnt_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 no late count", count, exp_cnt);
        apply(1'b0, 1'b0, -1, "R10 resumes R5");
    endtask

    task automatic test_small_reload();
        reload = 16'd1;
        apply(1'b1, 1'b0, 1, "R8 count above reload wraps");
        reload = 16'd0;
        apply(1'b1, 1'b1, 1, "R8 reload zero up");
        apply(1'b1, 1'b0, -1, "R9 reload zero down");
    endtask

    initial begin
        test_reset();
        test_both_up();
        test_wrap_up();
        test_wrap_down();
        test_latency();
        test_mode_a();
        test_mode_b();
        test_simultaneous();
        test_disable();
        test_small_reload();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule